// File: doc/BRIEF.md
# Vectored Multi-Level Interrupt Controller

This block gathers interrupt request flags from on-chip sources (timers, a serial port, a converter, a software source and external pins), holds them as pending flags, and selects one winner to present to a processor core. Twelve vectors exist. Each vector has an enable bit and a two-bit priority level formed from one bit in each of two priority words. A global enable gates all of them. Two vectors are shared: each is requested when either of its two flags is set.

The winner is the pending, enabled vector with the highest level. Among vectors of equal level the one with the lower vector address wins. A vector may interrupt only when its level is strictly above every level already in service. The core takes the presented vector with an acknowledge strobe. That pushes the winner's level into the in-service record and clears the winner's flag in hardware, except on the two shared vectors, whose flags software clears. A return strobe ends the most recent service.

All outputs are registered. They describe the controller state as it stands after each clock edge.

Top module: `irqc_vector_ctrl`

## Requirements
- R1: After synchronous reset, `irq` is 0, `irq_vec` is 0, `in_svc` is 0, `act_lvl` is 0 and all bits of `flags` are 0.
- R2: Vector index i (0..11) has the address 0003h + 8*i for i < 6 and 0043h + 8*(i-6) for i >= 6. When `irq` is 1, `irq_vec` holds the winner's address. When `irq` is 0, `irq_vec` is 0.
- R3: Bit f of `flag_set` sets flag f and bit f of `flag_clr` clears it. When both are high in the same cycle, the flag ends up set. Flags 0..11 are the primary flags of vectors 0..11. Flag 12 is the second flag of vector 4 and flag 13 is the second flag of vector 5.
- R4: Vector 4 is requested when flag 4 or flag 12 is set. Vector 5 is requested when flag 5 or flag 13 is set.
- R5: A vector competes only while its bit in `vec_en` is 1.
- R6: While `glob_en` is 0, `irq` is 0 and the pending flags keep their values.
- R7: The level of vector i is {`prio_hi[i]`, `prio_lo[i]`}. The highest level wins, and a tie goes to the lower index.
- R8: A vector is presented only if its level is strictly greater than the highest level in service. `act_lvl` shows that highest level, and `in_svc` is 1 while any level is in service.
- R9: `irq_ack` while `irq` is 1 puts the winner's level in service and clears the winner's primary flag, except for vectors 4 and 5. A `flag_set` of that same flag in the same cycle wins over the clear.
- R10: `irq_ret` removes the highest level in service. When `irq_ack` and `irq_ret` arrive in the same cycle, the removal is applied first and then the new level is added.
- R11: Changes on the inputs appear on `irq`, `irq_vec`, `act_lvl`, `in_svc` and `flags` after exactly one clock edge.
- R12: `irq_ack` while `irq` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_set | input | 14 | Per-flag set strobes |
| flag_clr | input | 14 | Per-flag clear strobes |
| vec_en | input | 12 | Per-vector enable |
| glob_en | input | 1 | Global enable |
| prio_hi | input | 12 | Upper priority bit per vector |
| prio_lo | input | 12 | Lower priority bit per vector |
| irq_ack | input | 1 | Core takes the presented vector |
| irq_ret | input | 1 | Core ends the current service |
| irq | output | 1 | Request to the core |
| irq_vec | output | 16 | Address of the presented vector |
| act_lvl | output | 2 | Highest level in service |
| in_svc | output | 1 | Any level in service |
| flags | output | 14 | Pending flags |

## Verification
Two pairs of events can land on the same clock edge. The first is an acknowledge together with a return: the record must drop the old top level and then take on the new one. The second is a hardware clear of a flag on acknowledge together with a fresh set of that same flag: the set must survive. Directed steps drive both pairs on purpose, and a long random phase drives acknowledge, return, set and clear strobes independently so that the pairs recur many times. On every clock a behavioural model, which keeps the in-service levels in a queue, judges all outputs.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_VEC  = 12;
  localparam int BANK_LEN = 6;
  localparam int NUM_XTRA = 2;
  localparam int NUM_FLAG = NUM_VEC + NUM_XTRA;
  localparam int LVL_W    = 2;
  localparam int NUM_LVL  = 1 << LVL_W;
  localparam int ADDR_W   = 16;
  localparam int VIDX_W   = $clog2(NUM_VEC);
  localparam int STRIDE   = 8;
  localparam logic [ADDR_W-1:0] BANK0_BASE = 16'h0003;
  localparam logic [ADDR_W-1:0] BANK1_BASE = 16'h0043;
  // vectors whose flags are merged and left for software to clear
  localparam int SHARED_A = 4;
  localparam int SHARED_B = 5;
  localparam logic [NUM_VEC-1:0] HW_CLR_MASK = 12'hFCF;

  function automatic logic [ADDR_W-1:0] vec_addr(input int idx);
    if (idx < BANK_LEN) return BANK0_BASE + ADDR_W'(STRIDE * idx);
    return BANK1_BASE + ADDR_W'(STRIDE * (idx - BANK_LEN));
  endfunction

  function automatic int flag_owner(input int f);
    if (f < NUM_VEC) return f;
    if (f == NUM_VEC) return SHARED_A;
    return SHARED_B;
  endfunction
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
  import irqc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_FLAG-1:0] set_i,
  input  logic [NUM_FLAG-1:0] clr_i,
  input  logic                hw_clr_en,
  input  logic [VIDX_W-1:0]   hw_clr_idx,
  output logic [NUM_FLAG-1:0] flags_q,
  output logic [NUM_FLAG-1:0] flags_n,
  output logic [NUM_VEC-1:0]  vec_req_n
);
  logic [NUM_FLAG-1:0] hwc;

  for (genvar f = 0; f < NUM_FLAG; f++) begin : g_hwc
    if (f < NUM_VEC) begin : g_prim
      assign hwc[f] = hw_clr_en && HW_CLR_MASK[f] && (hw_clr_idx == VIDX_W'(f));
    end else begin : g_xtra
      assign hwc[f] = 1'b0;
    end
  end

  assign flags_n = (flags_q & ~(clr_i | hwc)) | set_i;

  always_comb begin
    vec_req_n = '0;
    for (int f = 0; f < NUM_FLAG; f++)
      vec_req_n[flag_owner(f)] = vec_req_n[flag_owner(f)] | flags_n[f];
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_n;
  end

  for (genvar f = 0; f < NUM_FLAG; f++) begin : g_chk
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
      set_i[f] |=> flags_q[f]);
    if (f < NUM_VEC) begin : g_hw
      assert_hw_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (hw_clr_en && hw_clr_idx == VIDX_W'(f) && !set_i[f] && HW_CLR_MASK[f]) |=> !flags_q[f]);
    end
  end
endmodule

// File: rtl/irqc_level_stack.sv
module irqc_level_stack
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [LVL_W-1:0]   push_lvl,
  input  logic               pop,
  output logic [NUM_LVL-1:0] stk_q,
  output logic [NUM_LVL-1:0] stk_n,
  output logic [LVL_W-1:0]   top_n,
  output logic               busy_n
);
  logic [LVL_W-1:0]   top_q;
  logic [NUM_LVL-1:0] pop_mask;
  logic [NUM_LVL-1:0] push_mask;

  always_comb begin
    top_q = '0;
    for (int i = 0; i < NUM_LVL; i++)
      if (stk_q[i]) top_q = LVL_W'(i);
  end

  assign pop_mask  = (pop && |stk_q) ? (NUM_LVL'(1) << top_q) : '0;
  assign push_mask = push ? (NUM_LVL'(1) << push_lvl) : '0;
  assign stk_n     = (stk_q & ~pop_mask) | push_mask;
  assign busy_n    = |stk_n;

  always_comb begin
    top_n = '0;
    for (int i = 0; i < NUM_LVL; i++)
      if (stk_n[i]) top_n = LVL_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) stk_q <= '0;
    else     stk_q <= stk_n;
  end

  assert_pop_one_R10: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && |stk_q) |=> ($countones(stk_q) + 1 == $countones($past(stk_q))));
  assert_push_mark_R9: assert property (@(posedge clk) disable iff (rst)
    push |=> stk_q[$past(push_lvl)]);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic [NUM_VEC-1:0] vec_req,
  input  logic [NUM_VEC-1:0] vec_en,
  input  logic               glob_en,
  input  logic [NUM_VEC-1:0] prio_hi,
  input  logic [NUM_VEC-1:0] prio_lo,
  input  logic [NUM_LVL-1:0] stk,
  output logic               win_valid,
  output logic [VIDX_W-1:0]  win_idx,
  output logic [LVL_W-1:0]   win_lvl
);
  logic [LVL_W-1:0]   lvl [NUM_VEC];
  logic [NUM_VEC-1:0] elig;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign lvl[v]  = {prio_hi[v], prio_lo[v]};
    assign elig[v] = vec_req[v] && vec_en[v] && glob_en && ((stk >> lvl[v]) == '0);
  end

  // scan from the top index down so that a tie keeps the lower index
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (elig[i] && (!win_valid || lvl[i] >= win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = VIDX_W'(i);
        win_lvl   = lvl[i];
      end
    end
  end
endmodule

// File: rtl/irqc_vector_ctrl.sv
module irqc_vector_ctrl
  import irqc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_FLAG-1:0] flag_set,
  input  logic [NUM_FLAG-1:0] flag_clr,
  input  logic [NUM_VEC-1:0]  vec_en,
  input  logic                glob_en,
  input  logic [NUM_VEC-1:0]  prio_hi,
  input  logic [NUM_VEC-1:0]  prio_lo,
  input  logic                irq_ack,
  input  logic                irq_ret,
  output logic                irq,
  output logic [ADDR_W-1:0]   irq_vec,
  output logic [LVL_W-1:0]    act_lvl,
  output logic                in_svc,
  output logic [NUM_FLAG-1:0] flags
);
  logic                irq_q;
  logic [ADDR_W-1:0]   vec_q;
  logic [VIDX_W-1:0]   win_idx_q;
  logic [LVL_W-1:0]    win_lvl_q;
  logic [LVL_W-1:0]    act_lvl_q;
  logic                busy_q;
  logic                ack_eff;
  logic [NUM_FLAG-1:0] flags_q, flags_n;
  logic [NUM_VEC-1:0]  vec_req_n;
  logic [NUM_LVL-1:0]  stk_q, stk_n;
  logic [LVL_W-1:0]    top_n;
  logic                busy_n;
  logic                win_valid;
  logic [VIDX_W-1:0]   win_idx;
  logic [LVL_W-1:0]    win_lvl;

  assign ack_eff = irq_ack && irq_q;

  irqc_flag_bank u_flags (
    .clk        (clk),
    .rst        (rst),
    .set_i      (flag_set),
    .clr_i      (flag_clr),
    .hw_clr_en  (ack_eff),
    .hw_clr_idx (win_idx_q),
    .flags_q    (flags_q),
    .flags_n    (flags_n),
    .vec_req_n  (vec_req_n)
  );

  irqc_level_stack u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (ack_eff),
    .push_lvl (win_lvl_q),
    .pop      (irq_ret),
    .stk_q    (stk_q),
    .stk_n    (stk_n),
    .top_n    (top_n),
    .busy_n   (busy_n)
  );

  irqc_arbiter u_arb (
    .vec_req   (vec_req_n),
    .vec_en    (vec_en),
    .glob_en   (glob_en),
    .prio_hi   (prio_hi),
    .prio_lo   (prio_lo),
    .stk       (stk_n),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q     <= 1'b0;
      vec_q     <= '0;
      win_idx_q <= '0;
      win_lvl_q <= '0;
      act_lvl_q <= '0;
      busy_q    <= 1'b0;
    end else begin
      irq_q     <= win_valid;
      vec_q     <= win_valid ? vec_addr(int'(win_idx)) : '0;
      win_idx_q <= win_idx;
      win_lvl_q <= win_lvl;
      act_lvl_q <= top_n;
      busy_q    <= busy_n;
    end
  end

  assign irq     = irq_q;
  assign irq_vec = vec_q;
  assign act_lvl = act_lvl_q;
  assign in_svc  = busy_q;
  assign flags   = flags_q;

  assert_global_mask_R6: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> !irq_q);
  assert_strict_preempt_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_q && busy_q) |-> (win_lvl_q > act_lvl_q));
  assert_idle_ack_R12: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !irq_q && !irq_ret) |=> (stk_q == $past(stk_q)));
  assert_busy_match_R8: assert property (@(posedge clk) disable iff (rst)
    busy_q == (stk_q != '0));
endmodule

// File: tb/irqc_vector_ctrl_tb.sv
module irqc_vector_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] flag_set = '0, flag_clr = '0;
  logic [11:0] vec_en = '0, prio_hi = '0, prio_lo = '0;
  logic        glob_en = 1'b0, irq_ack = 1'b0, irq_ret = 1'b0;
  logic        irq, in_svc;
  logic [15:0] irq_vec;
  logic [1:0]  act_lvl;
  logic [13:0] flags;

  int    n_chk = 0, n_fail = 0, cyc_cnt = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit [13:0] m_flags;
  int        m_stack[$];
  bit        m_irq;
  int        m_win, m_wlvl;

  always #2.5 clk = ~clk;

  irqc_vector_ctrl dut_i (
    .clk(clk), .rst(rst), .flag_set(flag_set), .flag_clr(flag_clr),
    .vec_en(vec_en), .glob_en(glob_en), .prio_hi(prio_hi), .prio_lo(prio_lo),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq(irq), .irq_vec(irq_vec),
    .act_lvl(act_lvl), .in_svc(in_svc), .flags(flags)
  );

  function automatic int exp_addr(input int i);
    return (i < 6) ? (3 + 8 * i) : ('h43 + 8 * (i - 6));
  endfunction

  function automatic bit m_pend(input int i);
    bit f;
    f = m_flags[i] || (i == 4 && m_flags[12]) || (i == 5 && m_flags[13]);
    return f && vec_en[i] && glob_en;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc_cnt);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  // reference model update
  always @(posedge clk) begin
    if (rst) begin
      m_flags = '0;
      m_stack.delete();
      m_irq = 0; m_win = 0; m_wlvl = 0;
    end else begin
      bit        ack_eff;
      bit [13:0] nf;
      int        top;
      ack_eff = irq_ack && m_irq;
      for (int f = 0; f < 14; f++) begin
        nf[f] = m_flags[f];
        if (ack_eff && f == m_win && m_win != 4 && m_win != 5) nf[f] = 0;
        if (flag_clr[f]) nf[f] = 0;
        if (flag_set[f]) nf[f] = 1;
      end
      m_flags = nf;
      if (irq_ret && m_stack.size() > 0) void'(m_stack.pop_back());
      if (ack_eff) m_stack.push_back(m_wlvl);
      top = (m_stack.size() > 0) ? m_stack[$] : -1;
      m_irq = 0;
      for (int l = 3; l > top; l--)
        for (int i = 0; i < 12; i++)
          if (!m_irq && m_pend(i) && (2 * prio_hi[i] + prio_lo[i]) == l) begin
            m_irq = 1; m_win = i; m_wlvl = l;
          end
    end
  end

  // comparison on every clock, away from the active edge (R11)
  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "irq", irq, m_irq);
      chk(cur_req, "irq_vec", irq_vec, m_irq ? exp_addr(m_win) : 0);
      chk(cur_req, "act_lvl", act_lvl, (m_stack.size() > 0) ? m_stack[$] : 0);
      chk(cur_req, "in_svc", in_svc, m_stack.size() > 0);
      chk(cur_req, "flags", flags, m_flags);
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_fail++;
      $display("FAIL R11 watchdog: cycles=%0d expected below 150000", cyc_cnt);
      finish_test();
    end
  end

  initial begin
    repeat (3) nxt();
    rst = 1'b0;
    nxt();
    cur_req = "R1";
    chk("R1", "irq", irq, 0);
    chk("R1", "irq_vec", irq_vec, 0);
    chk("R1", "in_svc", in_svc, 0);
    chk("R1", "flags", flags, 0);

    // R2 / R9: each vector alone
    cur_req = "R2";
    glob_en = 1;
    for (int i = 0; i < 12; i++) begin
      vec_en = 12'(1 << i);
      flag_set = 14'(1 << i);
      nxt(); flag_set = '0;
      chk("R2", "vec", irq_vec, exp_addr(i));
      chk("R11", "irq", irq, 1);
      irq_ack = 1; nxt(); irq_ack = 0;
      chk("R9", "flag after ack", flags[i], (i == 4 || i == 5));
      chk("R9", "in_svc", in_svc, 1);
      flag_clr = '1; irq_ret = 1; nxt(); flag_clr = '0; irq_ret = 0;
      chk("R10", "in_svc", in_svc, 0);
    end

    // R4 shared vectors
    cur_req = "R4";
    vec_en = 12'h030;
    flag_set = 14'(1 << 12); nxt(); flag_set = '0;
    chk("R4", "vec via flag 12", irq_vec, 16'h0023);
    flag_clr = 14'(1 << 12); flag_set = 14'(1 << 13); nxt(); flag_set = '0; flag_clr = '0;
    chk("R4", "vec via flag 13", irq_vec, 16'h002B);
    flag_clr = '1; nxt(); flag_clr = '0;

    // R6 global mask
    cur_req = "R6";
    vec_en = '1; glob_en = 0;
    flag_set = 14'h0081; nxt(); flag_set = '0; nxt();
    chk("R6", "irq masked", irq, 0);
    chk("R6", "flags kept", flags, 14'h0081);
    glob_en = 1; nxt();
    chk("R7", "tie to lower index", irq_vec, 16'h0003);
    cur_req = "R5";
    vec_en = 12'hFFE; nxt();
    chk("R5", "disabled vector skipped", irq_vec, 16'h004B);

    // R7 levels
    cur_req = "R7";
    vec_en = '1; prio_hi[7] = 1; nxt();
    chk("R7", "higher level wins", irq_vec, 16'h004B);
    prio_hi[0] = 1; prio_lo[0] = 1; nxt();
    chk("R7", "level 3 wins", irq_vec, 16'h0003);

    // R8 nesting
    cur_req = "R8";
    irq_ack = 1; nxt(); irq_ack = 0;
    chk("R8", "lower level held", irq, 0);
    chk("R8", "act_lvl", act_lvl, 3);
    irq_ret = 1; nxt(); irq_ret = 0;
    chk("R8", "released", irq_vec, 16'h004B);
    irq_ack = 1; nxt(); irq_ack = 0;
    prio_hi[1] = 1; flag_set = 14'(1 << 1); nxt(); flag_set = '0;
    chk("R8", "equal level held", irq, 0);
    prio_hi[2] = 1; prio_lo[2] = 1; flag_set = 14'(1 << 2); nxt(); flag_set = '0;
    chk("R8", "higher level preempts", irq_vec, 16'h0013);

    // R10 ack and return together
    cur_req = "R10";
    irq_ack = 1; irq_ret = 1; nxt(); irq_ack = 0; irq_ret = 0;
    chk("R10", "act_lvl after swap", act_lvl, 3);
    chk("R10", "in_svc after swap", in_svc, 1);
    irq_ret = 1; nxt(); irq_ret = 0;
    chk("R10", "pending after pop", irq_vec, 16'h000B);

    // R12 ack with no request
    cur_req = "R12";
    glob_en = 0; nxt();
    irq_ack = 1; nxt(); irq_ack = 0;
    chk("R12", "in_svc", in_svc, 0);
    chk("R12", "flag kept", flags[1], 1);

    // R9 set against hardware clear
    cur_req = "R9";
    glob_en = 1; nxt();
    irq_ack = 1; flag_set = 14'(1 << 1); nxt(); irq_ack = 0; flag_set = '0;
    chk("R9", "set beats hw clear", flags[1], 1);
    chk("R9", "act_lvl", act_lvl, 2);
    irq_ret = 1; flag_clr = '1; nxt(); irq_ret = 0; flag_clr = '0;

    // R3 set against clear
    cur_req = "R3";
    vec_en = '0;
    flag_set = 14'(1 << 3); flag_clr = 14'(1 << 3); nxt(); flag_set = '0; flag_clr = '0;
    chk("R3", "set beats clear", flags[3], 1);
    flag_clr = 14'(1 << 3); nxt(); flag_clr = '0;
    chk("R3", "cleared", flags[3], 0);

    // random phase judged by the model
    cur_req = "R7";
    for (int c = 0; c < 4000; c++) begin
      if (c % 200 == 0) begin
        vec_en = 12'($urandom); prio_hi = 12'($urandom); prio_lo = 12'($urandom);
      end
      for (int f = 0; f < 14; f++) begin
        flag_set[f] = ($urandom % 12 == 0);
        flag_clr[f] = ($urandom % 30 == 0);
      end
      glob_en = ($urandom % 20 != 0);
      irq_ack = $urandom % 2;
      irq_ret = ($urandom % 5 == 0);
      nxt();
    end
    finish_test();
  end
endmodule